// File: doc/BRIEF.md
# Fractional Clock Divider with Triggered Commit

This block turns a stream of source clock ticks into a slower stream of clock-enable pulses. Each pulse marks one output period. The divisor is programmed through a 32-bit register. Its divisor field holds the divisor minus one, in fixed point with `FRAC_W` fractional bits. The effective scaled divisor is therefore `field + 2^FRAC_W`, so a field of zero divides by one. A phase accumulator produces non-integer ratios: on average, every `(field + 2^FRAC_W) / 2^FRAC_W` selected ticks yield one pulse.

The register holds a shadow copy of both the divisor field and a parent-selector code. Writes land in the shadow only. Setting the trigger bit in the same write starts an update. The trigger bit then reads one until the new settings have been loaded at an output-period boundary, and clears itself. A parent multiplexer chooses which source tick stream drives the accumulator. Each parent is identified by a programmable selector code. A code that matches no parent is flagged, and it is never loaded.

The selected source must keep ticking while an update is pending, because the update can only land on an output boundary.

Top module: `frac_clk_div`

## Requirements
- R1: After reset, the read value shows a divisor field of 0, the selector code of parent 0 (1 by default) and a trigger bit of 0. `clk_en` is low, `sel_idx` is 0 and `sel_bad` is low.
- R2: Let f be the active field. Over N selected ticks that follow a commit, exactly floor(N·2^FRAC_W/(f+2^FRAC_W)) pulses appear on `clk_en`. With f = 0, every selected tick gives a pulse one cycle later.
- R3: A write with the trigger bit at 0 changes only the read-back shadow fields. The output rate is unchanged.
- R4: The register layout is: trigger at bit `TRIG_BIT` (0), selector code at bits `SEL_SHIFT`+:`SEL_W` ([5:4]), divisor field at bits `DIV_SHIFT`+:`DIV_W` ([13:8]). All other written bits are ignored and read as 0.
- R5: After a write with the trigger bit set, the trigger bit reads 1 from the next cycle on. It clears itself on the cycle the new settings become active.
- R6: A commit happens only on an output pulse. It comes after at least one complete output period of the old divisor, counted from the boundary after the trigger. The accumulator restarts from zero at the commit.
- R7: While the selected source does not tick, a pending update stays pending and no pulse is produced.
- R8: Any write that arrives while the trigger bit reads 1 is ignored entirely.
- R9: Parent i is chosen by the code in slice i of `PARENT_CODES` (default: code 1 selects parent 0, code 3 selects parent 1; the lowest matching index wins). `sel_idx` shows the committed parent. Only that parent's ticks advance the divider.
- R10: `sel_bad` is high while the shadow selector code matches no parent (codes 0 and 2 by default). A commit with such a code keeps the current parent, but still loads the divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Shadow fields and trigger/busy bit |
| src_tick | input | NPAR | Per-parent source tick qualifiers |
| clk_en | output | 1 | Divided clock-enable pulse |
| sel_idx | output | IW | Index of the committed parent |
| sel_bad | output | 1 | Shadow selector code matches no parent |

## Verification
A wrong accumulator remainder or a wrong active divisor would first show as a pulse that comes early or late. Over a window of a hundred ticks it would also show as a pulse count that differs from the floor formula. A trigger state machine stuck in a busy state would leave the trigger bit set indefinitely. A state machine that commits early would clear the bit inside the first output period, or would clear it on a cycle with no pulse, and that is visible on the very cycle it happens. A wrong selector decode would show immediately on `sel_idx` after the commit, and as pulses driven by a parent that is not ticking.

// File: rtl/frac_div_pkg.sv
`timescale 1ns/1ps
package frac_div_pkg;

  typedef enum logic [1:0] {
    TRG_IDLE = 2'd0,
    TRG_SYNC = 2'd1,
    TRG_LOAD = 2'd2
  } trig_state_e;

  // Scaled divisor: stored field plus one unit in fixed point.
  function automatic logic [31:0] scaled_div(input logic [31:0] field,
                                             input int unsigned frac_w);
    return field + (32'd1 << frac_w);
  endfunction

  // Place a field into an otherwise zero 32-bit word.
  function automatic logic [31:0] place_field(input logic [31:0] val,
                                              input int unsigned shift);
    return val << shift;
  endfunction

endpackage

// File: rtl/frac_div_ctrl.sv
`timescale 1ns/1ps
module frac_div_ctrl #(
  parameter int unsigned DIV_W     = 6,
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned DIV_SHIFT = 8,
  parameter int unsigned SEL_SHIFT = 4,
  parameter int unsigned TRIG_BIT  = 0,
  parameter logic [DIV_W-1:0] RST_DIV = '0,
  parameter logic [SEL_W-1:0] RST_SEL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [31:0]      reg_wdata,
  input  logic             wrap,
  output logic [DIV_W-1:0] shadow_div,
  output logic [SEL_W-1:0] shadow_sel,
  output logic             busy,
  output logic             commit,
  output logic [31:0]      reg_rdata
);
  import frac_div_pkg::*;

  trig_state_e state_q;
  logic        accept_wr;
  logic        trig_req;
  logic        unused_wdata;

  assign unused_wdata = ^reg_wdata;
  assign busy      = (state_q != TRG_IDLE);
  assign accept_wr = reg_we && !busy;
  assign trig_req  = accept_wr && reg_wdata[TRIG_BIT];
  assign commit    = (state_q == TRG_LOAD) && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= TRG_IDLE;
      shadow_div <= RST_DIV;
      shadow_sel <= RST_SEL;
    end else begin
      if (accept_wr) begin
        shadow_div <= reg_wdata[DIV_SHIFT +: DIV_W];
        shadow_sel <= reg_wdata[SEL_SHIFT +: SEL_W];
      end
      unique case (state_q)
        TRG_IDLE: if (trig_req) state_q <= TRG_SYNC;
        TRG_SYNC: if (wrap)     state_q <= TRG_LOAD;
        TRG_LOAD: if (wrap)     state_q <= TRG_IDLE;
        default:                state_q <= TRG_IDLE;
      endcase
    end
  end

  always_comb begin
    reg_rdata = place_field(32'(shadow_div), DIV_SHIFT)
              | place_field(32'(shadow_sel), SEL_SHIFT)
              | place_field(32'(busy), TRIG_BIT);
  end

endmodule

// File: rtl/frac_div_srcsel.sv
`timescale 1ns/1ps
module frac_div_srcsel #(
  parameter int unsigned NPAR  = 2,
  parameter int unsigned SEL_W = 2,
  parameter int unsigned IW    = 1,
  parameter logic [NPAR*SEL_W-1:0] PARENT_CODES = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPAR-1:0]  src_tick,
  input  logic [SEL_W-1:0] shadow_sel,
  input  logic             commit,
  output logic             sel_tick,
  output logic [IW-1:0]    act_idx,
  output logic             sel_bad
);
  logic          hit;
  logic [IW-1:0] hit_idx;

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < int'(NPAR); i++) begin
      if (!hit && shadow_sel == PARENT_CODES[i*SEL_W +: SEL_W]) begin
        hit     = 1'b1;
        hit_idx = IW'(i);
      end
    end
  end

  assign sel_bad = !hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             act_idx <= '0;
    else if (commit && hit) act_idx <= hit_idx;
  end

  generate
    if (NPAR == 1) begin : g_single
      logic unused_idx;
      assign unused_idx = ^act_idx;
      assign sel_tick   = src_tick[0];
    end else begin : g_mux
      assign sel_tick = src_tick[act_idx];
    end
  endgenerate

endmodule

// File: rtl/frac_div_accum.sv
`timescale 1ns/1ps
module frac_div_accum #(
  parameter int unsigned DIV_W  = 6,
  parameter int unsigned FRAC_W = 2,
  parameter logic [DIV_W-1:0] RST_DIV = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             commit,
  input  logic [DIV_W-1:0] shadow_div,
  output logic             wrap,
  output logic             clk_en,
  output logic [DIV_W-1:0] act_div
);
  import frac_div_pkg::*;

  localparam int unsigned AW = DIV_W + 2;
  localparam logic [AW-1:0] ONE = AW'(1) << FRAC_W;

  logic [AW-1:0] acc_q;
  logic [AW-1:0] acc_nxt;
  logic [AW-1:0] dsc;

  assign dsc     = AW'(scaled_div(32'(act_div), FRAC_W));
  assign acc_nxt = acc_q + ONE;
  assign wrap    = tick && (acc_nxt >= dsc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      act_div <= RST_DIV;
      clk_en  <= 1'b0;
    end else begin
      clk_en <= wrap;
      if (commit) begin
        act_div <= shadow_div;
        acc_q   <= '0;
      end else if (wrap) begin
        acc_q <= acc_nxt - dsc;
      end else if (tick) begin
        acc_q <= acc_nxt;
      end
    end
  end

endmodule

// File: rtl/frac_clk_div.sv
`timescale 1ns/1ps
module frac_clk_div #(
  parameter int unsigned DIV_W     = 6,
  parameter int unsigned FRAC_W    = 2,
  parameter int unsigned DIV_SHIFT = 8,
  parameter int unsigned SEL_SHIFT = 4,
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned TRIG_BIT  = 0,
  parameter int unsigned NPAR      = 2,
  parameter logic [NPAR*SEL_W-1:0] PARENT_CODES = 4'b1101,
  parameter logic [DIV_W-1:0] RST_DIV = '0,
  localparam int unsigned IW = (NPAR > 1) ? $clog2(NPAR) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic [NPAR-1:0] src_tick,
  output logic            clk_en,
  output logic [IW-1:0]   sel_idx,
  output logic            sel_bad
);
  localparam logic [SEL_W-1:0] RST_SEL = PARENT_CODES[SEL_W-1:0];

  logic [DIV_W-1:0] shadow_div_w;
  logic [SEL_W-1:0] shadow_sel_w;
  logic [DIV_W-1:0] act_div_w;
  logic             busy_w;
  logic             commit_w;
  logic             wrap_w;
  logic             sel_tick_w;
  logic             trig_wr_w;

  assign trig_wr_w = reg_wdata[TRIG_BIT];

  frac_div_ctrl #(
    .DIV_W(DIV_W), .SEL_W(SEL_W), .DIV_SHIFT(DIV_SHIFT),
    .SEL_SHIFT(SEL_SHIFT), .TRIG_BIT(TRIG_BIT),
    .RST_DIV(RST_DIV), .RST_SEL(RST_SEL)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .wrap(wrap_w), .shadow_div(shadow_div_w), .shadow_sel(shadow_sel_w),
    .busy(busy_w), .commit(commit_w), .reg_rdata(reg_rdata)
  );

  frac_div_srcsel #(
    .NPAR(NPAR), .SEL_W(SEL_W), .IW(IW), .PARENT_CODES(PARENT_CODES)
  ) u_srcsel (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .shadow_sel(shadow_sel_w),
    .commit(commit_w), .sel_tick(sel_tick_w), .act_idx(sel_idx),
    .sel_bad(sel_bad)
  );

  frac_div_accum #(
    .DIV_W(DIV_W), .FRAC_W(FRAC_W), .RST_DIV(RST_DIV)
  ) u_accum (
    .clk(clk), .rst_n(rst_n), .tick(sel_tick_w), .commit(commit_w),
    .shadow_div(shadow_div_w), .wrap(wrap_w), .clk_en(clk_en),
    .act_div(act_div_w)
  );

endmodule

// File: rtl/frac_clk_div_chk.sv
`timescale 1ns/1ps
module frac_clk_div_chk #(
  parameter int unsigned DIV_W = 6,
  parameter int unsigned NPAR  = 2,
  parameter int unsigned IW    = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic             trig_wr,
  input logic             busy,
  input logic             commit,
  input logic             wrap,
  input logic             sel_tick,
  input logic             clk_en,
  input logic [DIV_W-1:0] act_div,
  input logic [IW-1:0]    sel_idx
);

  a_r5_trig_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && trig_wr && !busy) |=> busy);

  a_r5_busy_held_until_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !commit) |=> busy);

  a_r5_commit_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy);

  a_r6_commit_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (wrap && busy));

  a_r3_active_div_held: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(act_div));

  a_r7_pulse_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en) |-> $past(sel_tick));

  a_r9_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sel_idx) < int'(NPAR));

endmodule

bind frac_clk_div frac_clk_div_chk #(
  .DIV_W(DIV_W), .NPAR(NPAR), .IW(IW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .trig_wr(trig_wr_w),
  .busy(busy_w), .commit(commit_w), .wrap(wrap_w), .sel_tick(sel_tick_w),
  .clk_en(clk_en), .act_div(act_div_w), .sel_idx(sel_idx)
);

// File: tb/frac_clk_div_bench.sv
`timescale 1ns/1ps
module frac_clk_div_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  src_tick = 2'b00;
  logic        clk_en;
  logic [0:0]  sel_idx;
  logic        sel_bad;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  frac_clk_div u_frac_clk_div (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .src_tick(src_tick), .clk_en(clk_en),
    .sel_idx(sel_idx), .sel_bad(sel_bad)
  );

  // Field f of the table, expected pulses over 120 ticks = floor(480/(f+4))
  localparam int NV = 6;
  localparam int VF [NV] = '{0, 4, 2, 1, 11, 63};
  localparam int VE [NV] = '{120, 60, 80, 96, 32, 7};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    reg_wdata = '0;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (reg_rdata[0] && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    if (cyc >= 3000) check(1'b0, "R5 trigger never cleared", cyc, 0);
  endtask

  task automatic count(input int n, output int pulses);
    pulses = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (clk_en) pulses++;
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int p;
    int cyc;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(reg_rdata == 32'h0000_0010, "R1 reset readback", reg_rdata, 32'h10);
    check(clk_en == 1'b0, "R1 clk_en low", clk_en, 0);
    check(sel_idx == 1'b0 && sel_bad == 1'b0, "R1 selector", {sel_idx, sel_bad}, 0);
    rst_n = 1'b1;
    src_tick = 2'b11;

    // R3 shadow write without trigger leaves divide-by-one active
    wr(32'h0000_3F10);
    check(reg_rdata == 32'h0000_3F10, "R3 shadow readback", reg_rdata, 32'h3F10);
    count(20, p);
    check(p == 20, "R3 rate unchanged (R2 divide by one)", p, 20);

    // R4 layout: stray bits ignored
    wr(32'hFFFF_FFFE);
    check(reg_rdata == 32'h0000_3F30, "R4 field layout", reg_rdata, 32'h3F30);
    check(sel_bad == 1'b0, "R4 code 3 valid", sel_bad, 0);
    wr(32'h0000_0010);

    // R2 table walk
    for (int i = 0; i < NV; i++) begin
      wr(32'((VF[i] << 8) | 32'h11));
      check(reg_rdata[0] == 1'b1, "R5 trigger reads one", reg_rdata[0], 1);
      wait_idle(cyc);
      check(clk_en == 1'b1, "R6 commit on pulse", clk_en, 1);
      count(120, p);
      check(p == VE[i], "R2 pulse count", p, VE[i]);
    end

    // R6 busy covers at least one full old period (D=67, >=16 ticks)
    wr(32'h0000_0011);
    wait_idle(cyc);
    check(cyc >= 16, "R6 busy length", cyc, 16);
    count(8, p);
    check(p == 8, "R6 new divisor active", p, 8);

    // R7 no ticks: pending update holds, no pulses
    src_tick = 2'b00;
    wr(32'h0000_0511);
    count(40, p);
    check(p == 0, "R7 no pulses", p, 0);
    check(reg_rdata[0] == 1'b1, "R7 still pending", reg_rdata[0], 1);

    // R8 write while busy ignored
    wr(32'h0000_0A11);
    check(reg_rdata == 32'h0000_0511, "R8 busy write ignored", reg_rdata, 32'h511);
    src_tick = 2'b11;
    wait_idle(cyc);
    check(reg_rdata == 32'h0000_0510, "R5 trigger self-clears", reg_rdata, 32'h510);
    count(60, p);
    check(p == 26, "R2 divisor 9/4", p, 26);

    // R9 parent switch to parent 1
    src_tick = 2'b01;
    wr(32'h0000_0031);
    wait_idle(cyc);
    check(sel_idx == 1'b1, "R9 parent index", sel_idx, 1);
    count(20, p);
    check(p == 0, "R9 unselected parent ignored", p, 0);
    src_tick = 2'b10;
    count(20, p);
    check(p == 20, "R9 selected parent drives", p, 20);

    // R10 invalid code
    wr(32'h0000_0420);
    check(sel_bad == 1'b1, "R10 invalid flagged", sel_bad, 1);
    wr(32'h0000_0421);
    wait_idle(cyc);
    check(sel_idx == 1'b1, "R10 parent kept", sel_idx, 1);
    count(120, p);
    check(p == 60, "R10 divisor still loaded", p, 60);
    src_tick = 2'b01;
    count(20, p);
    check(p == 0, "R10 parent 0 not selected", p, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule